// File: doc/BRIEF.md
# Double-Buffered Stream Allocation Table

This block holds the virtual-channel allocation table of a multi-stream link: a fixed set of entries, each pairing a stream source index with the number of time slots that stream gets. Software fills a shadow copy one entry at a time, then issues an update command. The active copy, which the slot multiplexer downstream reads, never changes partway through a frame. All entries switch together on a frame-boundary strobe.

An update command selects one of two commit paths. The first emits an allocation-change marker sequence for a fixed number of frames before the commit. The second commits at the next boundary with no marker. At the moment the command is accepted, the shadow copy is frozen into a staging bank. Software may then keep editing the shadow without affecting the commit already in flight. A pending flag stays high from command acceptance until the new table is active, so software can poll it. Both the active and the shadow copies can be read back by entry index.

Top module: `stream_alloc_table`

## Requirements
- R1: During and after reset, every shadow and active entry reads source 0 and slot count 0, and `pending`, `marker_on` and `commit_pulse` are low.
- R2: A cycle with `wr_en` high stores `wr_src` and `wr_slots` into shadow entry `wr_idx`. The shadow readback shows the new value from the next cycle on, and the active table is unchanged by the write.
- R3: `cmd_code` is decoded when `cmd_valid` is high: 0 means no action, 1 means update with marker, 2 means update without marker, and 3 is reserved and treated as no action.
- R4: `pending` rises in the cycle after an accepted update command. It stays high until the commit, and falls in the same cycle the new active table first becomes visible.
- R5: For an update without marker, the commit happens at the first `frame_sof` strictly after the command cycle. A boundary in the command cycle itself does not count.
- R6: For an update with marker, `marker_on` rises after the first `frame_sof` that follows the command and stays high for MARK_FRAMES frames. The commit happens at the boundary that ends the last marker frame, and `marker_on` falls in that same cycle.
- R7: The committed table is the shadow contents as of the command cycle, including a shadow write in that same cycle. Shadow writes made while `pending` is high are stored in the shadow but are not committed.
- R8: An update command issued while `pending` is high is ignored. It neither restarts nor changes the commit in progress.
- R9: `commit_pulse` is high for exactly one cycle, the first cycle in which the new active table is visible.
- R10: `rd_idx` selects the entry shown on both readback pairs, combinationally.
- R11: The active table changes only in a `commit_pulse` cycle, and then all entries change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow entry write strobe |
| wr_idx | input | $clog2(NUM_VC) | Shadow entry to write |
| wr_src | input | SRC_W | Stream source index to store |
| wr_slots | input | SLOT_W | Slot count to store |
| cmd_valid | input | 1 | Update command strobe |
| cmd_code | input | 2 | Update command code (0 none, 1 with marker, 2 without marker, 3 reserved) |
| frame_sof | input | 1 | Frame-boundary strobe |
| rd_idx | input | $clog2(NUM_VC) | Readback entry select |
| rd_act_src | output | SRC_W | Active entry source |
| rd_act_slots | output | SLOT_W | Active entry slot count |
| rd_shd_src | output | SRC_W | Shadow entry source |
| rd_shd_slots | output | SLOT_W | Shadow entry slot count |
| pending | output | 1 | Update accepted and not yet committed |
| marker_on | output | 1 | Allocation-change marker frames in progress |
| commit_pulse | output | 1 | One-cycle flag: new active table visible |

## Verification
Two functions can fall in the same cycle, and both collisions are provoked on purpose. In the first, a shadow write and an update command arrive together, and the committed table must contain the value just written. In the second, an update command and a frame boundary arrive together, and that boundary must not count toward the commit. A third case drives a commit boundary while a shadow write is in progress, and the bench checks that the write reaches only the shadow. A behavioural model in the bench predicts every output and every readback entry on every cycle, so any deviation in timing or content shows up in the cycle where it occurs.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'd0,
        CMD_MARKED = 2'd1,
        CMD_PLAIN  = 2'd2,
        CMD_RSVD   = 2'd3
    } sat_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM_MARK,
        ST_MARKING,
        ST_ARM_PLAIN
    } sat_state_e;

    // Maps a command code to the state it arms; ST_IDLE means no action.
    function automatic sat_state_e cmd_target(input logic [1:0] code);
        case (sat_cmd_e'(code))
            CMD_MARKED: return ST_ARM_MARK;
            CMD_PLAIN:  return ST_ARM_PLAIN;
            default:    return ST_IDLE;
        endcase
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sat_reg_bank.sv
`timescale 1ns/1ps
module sat_reg_bank #(
    parameter int N  = 4,
    parameter int W  = 9,
    parameter int IW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_all,
    input  logic [N*W-1:0] ld_d,
    input  logic           wr_one,
    input  logic [IW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_d,
    output logic [N*W-1:0] q,
    output logic [N*W-1:0] q_nxt
);
    // One register per entry; a whole-bank load wins over a single-entry write.
    for (genvar i = 0; i < N; i++) begin : g_ent
        always_comb begin
            if (ld_all)
                q_nxt[i*W +: W] = ld_d[i*W +: W];
            else if (wr_one && (wr_idx == IW'(i)))
                q_nxt[i*W +: W] = wr_d;
            else
                q_nxt[i*W +: W] = q[i*W +: W];
        end

        always_ff @(posedge clk) begin
            if (rst) q[i*W +: W] <= '0;
            else     q[i*W +: W] <= q_nxt[i*W +: W];
        end
    end
endmodule

// File: rtl/sat_commit_fsm.sv
`timescale 1ns/1ps
module sat_commit_fsm
    import sat_pkg::*;
#(
    parameter int MARK_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       frame_sof,
    output logic       accept,
    output logic       commit_go,
    output logic       pending,
    output logic       marker_on,
    output logic       commit_pulse
);
    localparam int CNT_W = cnt_width(MARK_FRAMES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MARK_FRAMES - 1);

    sat_state_e       st;
    logic [CNT_W-1:0] cnt;
    sat_state_e       tgt;

    assign tgt       = cmd_target(cmd_code);
    assign accept    = cmd_valid && (st == ST_IDLE) && (tgt != ST_IDLE);
    assign commit_go = frame_sof &&
                       ((st == ST_ARM_PLAIN) || ((st == ST_MARKING) && (cnt == LAST)));
    assign pending   = (st != ST_IDLE);
    assign marker_on = (st == ST_MARKING);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            cnt          <= '0;
            commit_pulse <= 1'b0;
        end else begin
            commit_pulse <= commit_go;
            case (st)
                ST_IDLE: begin
                    if (accept) st <= tgt;
                end
                ST_ARM_MARK: begin
                    if (frame_sof) begin
                        st  <= ST_MARKING;
                        cnt <= '0;
                    end
                end
                ST_MARKING: begin
                    if (frame_sof) begin
                        if (cnt == LAST) st <= ST_IDLE;
                        else             cnt <= cnt + 1'b1;
                    end
                end
                ST_ARM_PLAIN: begin
                    if (frame_sof) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stream_alloc_table.sv
`timescale 1ns/1ps
module stream_alloc_table
    import sat_pkg::*;
#(
    parameter int NUM_VC      = 4,
    parameter int SRC_W       = 3,
    parameter int SLOT_W      = 6,
    parameter int MARK_FRAMES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_VC)-1:0] wr_idx,
    input  logic [SRC_W-1:0]          wr_src,
    input  logic [SLOT_W-1:0]         wr_slots,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_code,
    input  logic                      frame_sof,
    input  logic [$clog2(NUM_VC)-1:0] rd_idx,
    output logic [SRC_W-1:0]          rd_act_src,
    output logic [SLOT_W-1:0]         rd_act_slots,
    output logic [SRC_W-1:0]          rd_shd_src,
    output logic [SLOT_W-1:0]         rd_shd_slots,
    output logic                      pending,
    output logic                      marker_on,
    output logic                      commit_pulse
);
    localparam int IW    = $clog2(NUM_VC);
    localparam int ENT_W = SRC_W + SLOT_W;
    localparam int TBL_W = NUM_VC * ENT_W;

    logic             accept;
    logic             commit_go;
    logic [TBL_W-1:0] shd_q, shd_nxt;
    logic [TBL_W-1:0] stg_q, stg_nxt;
    logic [TBL_W-1:0] act_q, act_nxt;
    logic [ENT_W-1:0] act_sel, shd_sel;

    sat_commit_fsm #(.MARK_FRAMES(MARK_FRAMES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .frame_sof    (frame_sof),
        .accept       (accept),
        .commit_go    (commit_go),
        .pending      (pending),
        .marker_on    (marker_on),
        .commit_pulse (commit_pulse)
    );

    // Shadow: software-facing, one entry per write.
    sat_reg_bank #(.N(NUM_VC), .W(ENT_W), .IW(IW)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .ld_all (1'b0),
        .ld_d   ('0),
        .wr_one (wr_en),
        .wr_idx (wr_idx),
        .wr_d   ({wr_src, wr_slots}),
        .q      (shd_q),
        .q_nxt  (shd_nxt)
    );

    // Staging: frozen copy of the shadow (with same-cycle write) on accept.
    sat_reg_bank #(.N(NUM_VC), .W(ENT_W), .IW(IW)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .ld_all (accept),
        .ld_d   (shd_nxt),
        .wr_one (1'b0),
        .wr_idx ('0),
        .wr_d   ('0),
        .q      (stg_q),
        .q_nxt  (stg_nxt)
    );

    // Active: loaded whole at the commit boundary.
    sat_reg_bank #(.N(NUM_VC), .W(ENT_W), .IW(IW)) u_active (
        .clk    (clk),
        .rst    (rst),
        .ld_all (commit_go),
        .ld_d   (stg_q),
        .wr_one (1'b0),
        .wr_idx ('0),
        .wr_d   ('0),
        .q      (act_q),
        .q_nxt  (act_nxt)
    );

    assign act_sel = act_q[rd_idx*ENT_W +: ENT_W];
    assign shd_sel = shd_q[rd_idx*ENT_W +: ENT_W];

    assign rd_act_src   = act_sel[ENT_W-1:SLOT_W];
    assign rd_act_slots = act_sel[SLOT_W-1:0];
    assign rd_shd_src   = shd_sel[ENT_W-1:SLOT_W];
    assign rd_shd_slots = shd_sel[SLOT_W-1:0];
endmodule

// File: rtl/stream_alloc_table_chk.sv
`timescale 1ns/1ps
module stream_alloc_table_chk #(
    parameter int TW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          frame_sof,
    input logic          pending,
    input logic          marker_on,
    input logic          commit_pulse,
    input logic [TW-1:0] act_q
);
    p_rise_after_cmd_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(cmd_valid));

    p_fall_with_commit_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> commit_pulse);

    p_commit_on_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> $past(frame_sof) && $past(pending));

    p_marker_in_pending_r6: assert property (@(posedge clk) disable iff (rst)
        marker_on |-> pending);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> !commit_pulse);

    p_pulse_clears_pending_r9: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> !pending);

    p_active_only_on_commit_r11: assert property (@(posedge clk) disable iff (rst)
        !commit_pulse |-> $stable(act_q));
endmodule

bind stream_alloc_table stream_alloc_table_chk #(.TW(TBL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .frame_sof    (frame_sof),
    .pending      (pending),
    .marker_on    (marker_on),
    .commit_pulse (commit_pulse),
    .act_q        (act_q)
);

// File: tb/stream_alloc_table_tb_top.sv
`timescale 1ns/1ps
module stream_alloc_table_tb_top;
    localparam int N  = 4;
    localparam int SW = 3;
    localparam int LW = 6;
    localparam int MF = 2;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [SW-1:0] wr_src = '0;
    logic [LW-1:0] wr_slots = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_code = 2'd0;
    logic          frame_sof = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [SW-1:0] rd_act_src, rd_shd_src;
    logic [LW-1:0] rd_act_slots, rd_shd_slots;
    logic          pending, marker_on, commit_pulse;

    stream_alloc_table #(.NUM_VC(N), .SRC_W(SW), .SLOT_W(LW), .MARK_FRAMES(MF)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_src(wr_src),
        .wr_slots(wr_slots), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .frame_sof(frame_sof), .rd_idx(rd_idx), .rd_act_src(rd_act_src),
        .rd_act_slots(rd_act_slots), .rd_shd_src(rd_shd_src),
        .rd_shd_slots(rd_shd_slots), .pending(pending), .marker_on(marker_on),
        .commit_pulse(commit_pulse)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Behavioural model: 0 idle, 1 waiting for marker start, 2 marker frames, 3 waiting plain.
    int m_sh_src[N], m_sh_sl[N], m_st_src[N], m_st_sl[N], m_ac_src[N], m_ac_sl[N];
    int m_mode = 0, m_frames = 0, m_pulse = 0;

    task automatic model_step();
        bit commit = 1'b0;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_sh_src[i] = 0; m_sh_sl[i] = 0; m_st_src[i] = 0;
                m_st_sl[i] = 0;  m_ac_src[i] = 0; m_ac_sl[i] = 0;
            end
            m_mode = 0; m_frames = 0; m_pulse = 0;
            return;
        end
        if (wr_en) begin
            m_sh_src[wr_idx] = wr_src;
            m_sh_sl[wr_idx]  = wr_slots;
        end
        case (m_mode)
            0: if (cmd_valid && (cmd_code == 2'd1 || cmd_code == 2'd2)) begin
                   for (int i = 0; i < N; i++) begin
                       m_st_src[i] = m_sh_src[i];
                       m_st_sl[i]  = m_sh_sl[i];
                   end
                   m_mode = (cmd_code == 2'd1) ? 1 : 3;
               end
            1: if (frame_sof) begin m_mode = 2; m_frames = 1; end
            2: if (frame_sof) begin
                   if (m_frames == MF) begin commit = 1'b1; m_mode = 0; end
                   else m_frames++;
               end
            3: if (frame_sof) begin commit = 1'b1; m_mode = 0; end
            default: m_mode = 0;
        endcase
        if (commit)
            for (int i = 0; i < N; i++) begin
                m_ac_src[i] = m_st_src[i];
                m_ac_sl[i]  = m_st_sl[i];
            end
        m_pulse = commit ? 1 : 0;
    endtask

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("pending", int'(pending), (m_mode != 0) ? 1 : 0);
        chk("marker_on", int'(marker_on), (m_mode == 2) ? 1 : 0);
        chk("commit_pulse R9", int'(commit_pulse), m_pulse);
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i);
            #0.5;
            chk($sformatf("active[%0d].src R11", i), int'(rd_act_src), m_ac_src[i]);
            chk($sformatf("active[%0d].slots R11", i), int'(rd_act_slots), m_ac_sl[i]);
            chk($sformatf("shadow[%0d].src R10", i), int'(rd_shd_src), m_sh_src[i]);
            chk($sformatf("shadow[%0d].slots R10", i), int'(rd_shd_slots), m_sh_sl[i]);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; cmd_valid = 1'b0; frame_sof = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic put(int idx, int src, int sl);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_src = SW'(src); wr_slots = LW'(sl);
    endtask

    task automatic read_active(int idx, output int src, output int sl);
        rd_idx = IW'(idx);
        #0.5;
        src = int'(rd_act_src);
        sl  = int'(rd_act_slots);
    endtask

    initial begin
        int s, l;
        // R1: reset state
        cur_tag = "R1";
        idle(3);
        rst = 1'b0;
        cyc();
        read_active(2, s, l);
        chk("active[2] after reset R1", s + l, 0);

        // R2 / R10: shadow writes leave active alone
        cur_tag = "R2 R10";
        put(0, 1, 10); cyc();
        put(1, 2, 20); cyc();
        put(2, 3, 30); cyc();
        put(3, 7, 63); cyc();
        read_active(3, s, l);
        chk("active[3] untouched by write R2", l, 0);

        // R3: codes 0 and 3 do nothing, even across boundaries
        cur_tag = "R3";
        cmd_valid = 1'b1; cmd_code = 2'd0; cyc();
        frame_sof = 1'b1; cyc();
        cmd_valid = 1'b1; cmd_code = 2'd3; cyc();
        frame_sof = 1'b1; cyc();
        chk("pending after nop/reserved R3", int'(pending), 0);

        // R5 / R4 / R9: plain update, command and boundary in the same cycle
        cur_tag = "R5 R4 R9";
        cmd_valid = 1'b1; cmd_code = 2'd2; frame_sof = 1'b1; cyc();
        chk("pending after plain cmd R4", int'(pending), 1);
        idle(3);
        frame_sof = 1'b1; cyc();
        chk("commit_pulse plain R9", int'(commit_pulse), 1);
        read_active(3, s, l);
        chk("active[3].slots after plain commit R5", l, 63);
        idle(1);

        // R6 / R7: marked update with same-cycle write, then writes while pending
        cur_tag = "R6 R7 R11";
        put(0, 5, 44); cmd_valid = 1'b1; cmd_code = 2'd1; cyc();
        idle(2);
        frame_sof = 1'b1; cyc();
        chk("marker_on after first boundary R6", int'(marker_on), 1);
        put(0, 6, 1); idle(2);
        frame_sof = 1'b1; put(1, 4, 9); cyc();
        chk("still marking R6", int'(marker_on), 1);
        idle(3);
        // R8: new command while pending is ignored
        cur_tag = "R8 R6";
        cmd_valid = 1'b1; cmd_code = 2'd2; cyc();
        idle(1);
        frame_sof = 1'b1; cyc();
        chk("marker_on after last marker frame R6", int'(marker_on), 0);
        read_active(0, s, l);
        chk("active[0].src is command-cycle snapshot R7", s, 5);
        chk("active[0].slots is command-cycle snapshot R7", l, 44);
        read_active(1, s, l);
        chk("active[1].slots ignores pending-time write R7", l, 20);
        idle(2);
        frame_sof = 1'b1; cyc();
        chk("no second commit from ignored cmd R8", int'(commit_pulse), 0);

        // R7: pending-time shadow edits commit on the next update
        cur_tag = "R7 R5";
        cmd_valid = 1'b1; cmd_code = 2'd2; cyc();
        frame_sof = 1'b1; put(2, 0, 0); cyc();
        read_active(0, s, l);
        chk("active[0].src after follow-up commit R7", s, 6);
        read_active(2, s, l);
        chk("active[2].slots excludes commit-cycle write R7", l, 30);
        idle(2);

        // R1: reset mid-update clears everything
        cur_tag = "R1";
        cmd_valid = 1'b1; cmd_code = 2'd1; cyc();
        rst = 1'b1; idle(2); rst = 1'b0; idle(2);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule